// File: doc/BRIEF.md
# Mirrored Bit-Memory Swap-and-Compare Scrubber

This block keeps two small single-bit memories that are meant to hold identical contents, and checks them against each other in the background. A free-running interval timer divides the refresh period into one slot per address. In each slot the controller reads the bit from the first copy into a one-bit holding register. It then lets the second copy drive the shared data line, writes that bit into the first copy and compares it with the held bit. Finally it drives the held bit back onto the line and writes it into the second copy. Every cell is rewritten once per period. A copy that has drifted is flagged on the next pass over its address.

Both copies sit on one address bus and one single-bit data line, so the controller gives the line to at most one source per cycle. Sequencing runs on the rising clock edge. Writes into the arrays are committed on the falling edge, so address and data have half a cycle to settle before the write and stay put until the cycle ends. A mismatch raises a sticky error flag and records the address that failed first. Both stay until a synchronous clear. The arrays are modelled as register arrays with reset images given by parameters, so a test can load them with contents that differ.

Top module: `mirrorScrub`

## Requirements
- R1: While `rstN` is low and on the first cycle after it rises: `errFlag`=0, `errAddr`=0, `memAddr`=0, and all enables (`memAOe`, `memBOe`, `bufOe`, `memAWe`, `memBWe`, `memACe`, `memBCe`) are 0.
- R2: A slot opens every SLOT = REFRESH_CYCLES/DEPTH cycles. The first slot's read cycle is the SLOT-th clock after reset is released.
- R3: Each slot runs three consecutive cycles in a fixed order: (a) `memAOe`=1; (b) `memBOe`=1 and `memAWe`=1; (c) `bufOe`=1 and `memBWe`=1. All other cycles have every enable at 0. `memACe` = `memAOe` | `memAWe` and `memBCe` = `memBOe` | `memBWe`.
- R4: At most one of `memAOe`, `memBOe`, `bufOe` is 1 in any cycle. While one of them is 1, `dataLine` carries that source's bit: copy A, copy B, or the held bit.
- R5: `memAddr` holds one value for a whole slot. It increments after cycle (c) and wraps from DEPTH-1 to 0.
- R6: After a slot, copy A at that address holds copy B's old bit and copy B holds copy A's old bit. The next pass over that address shows this on `dataLine`.
- R7: `errFlag` rises at the end of cycle (b) when the bit driven by copy B differs from the held bit read from copy A.
- R8: `errFlag` is sticky. `errAddr` captures the address of the first mismatch after reset or after a clear, and later mismatches leave it unchanged.
- R9: `clrErr` (active-high, sampled at the rising edge) clears `errFlag`. If a mismatch is detected in the same cycle, the flag stays set and `errAddr` takes the new address.
- R10: Array writes commit on the falling edge. `memAddr` and the written data do not change in a cycle whose write enable is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge sequencing, falling edge writes |
| rstN | input | 1 | Asynchronous active-low reset |
| clrErr | input | 1 | Synchronous clear of the error flag |
| memAddr | output | AW | Shared address bus |
| dataLine | output | 1 | Shared data line, high impedance when undriven |
| memACe | output | 1 | Copy A chip enable |
| memBCe | output | 1 | Copy B chip enable |
| memAOe | output | 1 | Copy A drives the line |
| memBOe | output | 1 | Copy B drives the line |
| bufOe | output | 1 | Holding register drives the line |
| memAWe | output | 1 | Copy A write enable |
| memBWe | output | 1 | Copy B write enable |
| errFlag | output | 1 | Sticky mismatch flag |
| errAddr | output | AW | Address of the first mismatch |

## Verification
A corrupted holding bit shows up within one cycle: the held value is on `dataLine` during cycle (c), and it sets a wrong `errFlag` at the end of cycle (b). An address counter or slot timer that slips moves `memAddr` or the enable pattern on the very next slot. A lost or duplicated write stays hidden until the same address comes round again, one full refresh period later. At that point `dataLine` in cycles (a) and (b) no longer matches the swapped reference contents. The bench loads two reset images that differ at two addresses. It runs several periods so that swaps, repeated flags, clears and a clear colliding with a new mismatch all occur.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  typedef struct packed {
    logic oeA;
    logic oeB;
    logic oeBuf;
    logic weA;
    logic weB;
    logic capBuf;
    logic cmp;
    logic advance;
  } strobe_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RDA  = 2'd1,
    PH_XFER = 2'd2,
    PH_WRB  = 2'd3
  } phase_t;

endpackage

// File: rtl/scrubCtrl.sv
module scrubCtrl
  import scrub_pkg::*;
#(
  parameter int unsigned REFRESH_CYCLES = 1025000000,
  parameter int unsigned DEPTH          = 8
) (
  input  logic    clk,
  input  logic    rstN,
  output strobe_t strobe
);

  localparam int unsigned SLOT = REFRESH_CYCLES / DEPTH;
  localparam int unsigned CW   = (SLOT > 2) ? $clog2(SLOT) : 1;
  localparam logic [CW-1:0] SLOT_LAST = CW'(SLOT - 1);

  logic [CW-1:0] slotCnt;
  phase_t        phase;
  phase_t        phaseNext;
  logic          slotEdge;

  assign slotEdge = (slotCnt == SLOT_LAST);

  // interval timer: one tick per slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slotCnt <= '0;
    else if (slotEdge) slotCnt <= '0;
    else slotCnt <= slotCnt + 1'b1;
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (slotEdge) phaseNext = PH_RDA;
      PH_RDA:  phaseNext = PH_XFER;
      PH_XFER: phaseNext = PH_WRB;
      PH_WRB:  phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else phase <= phaseNext;
  end

  // Moore strobes: stable for the whole cycle
  always_comb begin
    strobe = '0;
    unique case (phase)
      PH_RDA: begin
        strobe.oeA    = 1'b1;
        strobe.capBuf = 1'b1;
      end
      PH_XFER: begin
        strobe.oeB = 1'b1;
        strobe.weA = 1'b1;
        strobe.cmp = 1'b1;
      end
      PH_WRB: begin
        strobe.oeBuf   = 1'b1;
        strobe.weB     = 1'b1;
        strobe.advance = 1'b1;
      end
      default: strobe = '0;
    endcase
  end

  // R2
  slot_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.oeA |-> (slotCnt == '0));

  // R3
  seq_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.oeA |=> (strobe.oeB && strobe.weA));

  // R3
  seq_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.weA |=> (strobe.oeBuf && strobe.weB));

endmodule

// File: rtl/scrubPath.sv
module scrubPath
  import scrub_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned AW     = 3,
  parameter logic [DEPTH-1:0] INIT_A = '0,
  parameter logic [DEPTH-1:0] INIT_B = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clrErr,
  input  strobe_t       strobe,
  output logic [AW-1:0] memAddr,
  output logic          dataLine,
  output logic          errFlag,
  output logic [AW-1:0] errAddr
);

  localparam logic [AW-1:0] ADDR_LAST = AW'(DEPTH - 1);

  logic [DEPTH-1:0] memA;
  logic [DEPTH-1:0] memB;
  logic [AW-1:0]    addrReg;
  logic             bufBit;
  logic             lineVal;
  logic             anyDrive;
  logic             setErr;

  assign memAddr = addrReg;

  // shared line: single source selected by the strobes
  always_comb begin
    lineVal = 1'b0;
    if (strobe.oeA)        lineVal = memA[addrReg];
    else if (strobe.oeB)   lineVal = memB[addrReg];
    else if (strobe.oeBuf) lineVal = bufBit;
  end

  assign anyDrive = strobe.oeA | strobe.oeB | strobe.oeBuf;
  assign dataLine = anyDrive ? lineVal : 1'bz;

  // falling-edge writes into both copies
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      memA <= INIT_A;
      memB <= INIT_B;
    end else begin
      if (strobe.weA) memA[addrReg] <= lineVal;
      if (strobe.weB) memB[addrReg] <= lineVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bufBit <= 1'b0;
    else if (strobe.capBuf) bufBit <= lineVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrReg <= '0;
    else if (strobe.advance) addrReg <= (addrReg == ADDR_LAST) ? '0 : addrReg + 1'b1;
  end

  assign setErr = strobe.cmp && (lineVal != bufBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
      errAddr <= '0;
    end else begin
      errFlag <= setErr | (errFlag & ~clrErr);
      if (setErr && (!errFlag || clrErr)) errAddr <= addrReg;
    end
  end

  // R4
  drive_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.oeA, strobe.oeB, strobe.oeBuf}));

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.weA || strobe.weB) && !strobe.advance |=> $stable(addrReg));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !clrErr) |=> errFlag);

  // R7
  err_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(strobe.cmp));

  // R6
  buf_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capBuf |=> (bufBit == $past(lineVal)));

endmodule

// File: rtl/mirrorScrub.sv
module mirrorScrub
  import scrub_pkg::*;
#(
  parameter int unsigned REFRESH_CYCLES = 1025000000,
  parameter int unsigned DEPTH          = 8,
  parameter int unsigned AW             = $clog2(DEPTH),
  parameter logic [DEPTH-1:0] INIT_A    = '0,
  parameter logic [DEPTH-1:0] INIT_B    = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clrErr,
  output logic [AW-1:0] memAddr,
  output logic          dataLine,
  output logic          memACe,
  output logic          memBCe,
  output logic          memAOe,
  output logic          memBOe,
  output logic          bufOe,
  output logic          memAWe,
  output logic          memBWe,
  output logic          errFlag,
  output logic [AW-1:0] errAddr
);

  strobe_t strobe;

  scrubCtrl #(
    .REFRESH_CYCLES(REFRESH_CYCLES),
    .DEPTH(DEPTH)
  ) i_ctrl (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe)
  );

  scrubPath #(
    .DEPTH(DEPTH),
    .AW(AW),
    .INIT_A(INIT_A),
    .INIT_B(INIT_B)
  ) i_path (
    .clk(clk),
    .rstN(rstN),
    .clrErr(clrErr),
    .strobe(strobe),
    .memAddr(memAddr),
    .dataLine(dataLine),
    .errFlag(errFlag),
    .errAddr(errAddr)
  );

  assign memAOe = strobe.oeA;
  assign memBOe = strobe.oeB;
  assign bufOe  = strobe.oeBuf;
  assign memAWe = strobe.weA;
  assign memBWe = strobe.weB;
  assign memACe = strobe.oeA | strobe.weA;
  assign memBCe = strobe.oeB | strobe.weB;

endmodule

// File: tb/test_mirrorScrub.sv
module test_mirrorScrub;

  localparam int unsigned DEPTH = 8;
  localparam int unsigned AW    = 3;
  localparam int unsigned REF   = 48;
  localparam int unsigned SLOT  = REF / DEPTH;
  localparam logic [7:0] IA = 8'hB2;
  localparam logic [7:0] IB = 8'hB2 ^ 8'h48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clrErr = 1'b0;
  logic [AW-1:0] memAddr;
  logic dataLine, memACe, memBCe, memAOe, memBOe, bufOe, memAWe, memBWe, errFlag;
  logic [AW-1:0] errAddr;

  always #5 clk = ~clk;

  mirrorScrub #(
    .REFRESH_CYCLES(REF), .DEPTH(DEPTH), .AW(AW), .INIT_A(IA), .INIT_B(IB)
  ) i_mirrorScrub (
    .clk(clk), .rstN(rstN), .clrErr(clrErr), .memAddr(memAddr), .dataLine(dataLine),
    .memACe(memACe), .memBCe(memBCe), .memAOe(memAOe), .memBOe(memBOe), .bufOe(bufOe),
    .memAWe(memAWe), .memBWe(memBWe), .errFlag(errFlag), .errAddr(errAddr)
  );

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;

  // behavioural reference
  bit ma[8];
  bit mb[8];
  int mcnt, mph, maddr, mwraps;
  bit mbuf, merr;
  int merrAddr;

  task automatic chk(string req, int act, int exp, string what);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 8; i++) begin
      ma[i] = IA[i];
      mb[i] = IB[i];
    end
    mcnt = 0; mph = 0; maddr = 0; mwraps = 0; mbuf = 0; merr = 0; merrAddr = 0;
  endtask

  task automatic modelStep(bit clr);
    bit hit;
    int nph;
    hit = (mph == 2) && (mb[maddr] != mbuf);
    if (hit && (!merr || clr)) merrAddr = maddr;
    merr = hit ? 1'b1 : (clr ? 1'b0 : merr);
    if (mph == 1) mbuf = ma[maddr];
    if (mph == 2) ma[maddr] = mb[maddr];
    if (mph == 3) begin
      mb[maddr] = mbuf;
      if (maddr == 7) begin
        maddr = 0;
        mwraps++;
      end else maddr++;
    end
    nph = (mph == 0) ? ((mcnt == SLOT - 1) ? 1 : 0) : ((mph == 3) ? 0 : mph + 1);
    mcnt = (mcnt == SLOT - 1) ? 0 : mcnt + 1;
    mph = nph;
  endtask

  task automatic compareAll();
    string rq;
    chk("R3", memAOe, mph == 1, "memAOe");
    chk("R3", memBOe, mph == 2, "memBOe");
    chk("R3", bufOe,  mph == 3, "bufOe");
    chk("R3", memAWe, mph == 2, "memAWe");
    chk("R3", memBWe, mph == 3, "memBWe");
    chk("R3", memACe, (mph == 1) || (mph == 2), "memACe");
    chk("R3", memBCe, (mph == 2) || (mph == 3), "memBCe");
    chk("R4", int'(memAOe) + int'(memBOe) + int'(bufOe) <= 1, 1, "single driver");
    rq = (mwraps > 0) ? "R6" : "R4";
    if (mph == 1) chk(rq, dataLine, ma[maddr], "dataLine from copy A");
    if (mph == 2) chk(rq, dataLine, mb[maddr], "dataLine from copy B");
    if (mph == 3) chk("R4", dataLine, mbuf, "dataLine from buffer");
    chk("R5", memAddr, maddr, "memAddr");
    chk("R7", errFlag, merr, "errFlag");
    chk("R8", errAddr, merrAddr, "errAddr");
  endtask

  // clear driver: fixed clear plus one clear colliding with a detection (R9)
  always @(negedge clk) begin
    clrErr <= (cyc == 35) || (cyc == 130) || (mwraps == 1 && mph == 2 && maddr == 3);
  end

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else modelStep(clrErr);
    cyc++;
  end

  initial begin
    modelReset();
    #2;
    // R1 reset state
    chk("R1", errFlag, 0, "errFlag in reset");
    chk("R1", errAddr, 0, "errAddr in reset");
    chk("R1", memAddr, 0, "memAddr in reset");
    chk("R1", {memAOe, memBOe, bufOe, memAWe, memBWe, memACe, memBCe}, 0, "enables in reset");
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #2;
    chk("R1", {memAOe, memBOe, bufOe, memAWe, memBWe}, 0, "enables after reset");
    compareAll();
    // R2: read cycle lands on the SLOT-th clock after release
    for (int k = 2; k < SLOT; k++) begin
      @(posedge clk); #2;
      chk("R2", memAOe, 0, "no early read");
    end
    @(posedge clk); #2;
    chk("R2", memAOe, 1, "first read at SLOT");
    compareAll();
    for (int k = 0; k < 3 * REF + 20; k++) begin
      @(posedge clk); #2;
      compareAll();
    end
    chk("R5", mwraps >= 3, 1, "address wrapped several times");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    #100000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule